// File: doc/BRIEF.md
# Machine status register legalizer

This block holds the processor's machine status word and applies every rule a software write must obey before the value is stored. One write port carries a data word and a view select. In the machine view the whole word is offered. In the supervisor view only the bits that the lower privilege level may see are taken from the data, and the other bits keep their held value. Two capability inputs say whether supervisor mode and user mode exist. The block uses them to reject a previous-privilege value that names a mode the hart does not have.

After the merge the block legalises the word. The floating-point state field can only hold off or dirty. The summary dirty bit at the top of the word is rebuilt from the state fields. Any field outside the writable set keeps its value. Two combinational read ports return the full word and the supervisor view. A one-cycle flush pulse tells the address-translation logic when a write touches a bit that changes how addresses are translated.

Top module: `mstat_legalizer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the full read value is all zeros, the supervisor read value is zero and the flush output is low.
- R2: A machine-view write may change only these bits: 1, 3, 5, 7, 8, 11, 12, 13, 14, 17, 18 and 19. The summary bit 31 is rebuilt as R6 states. Every other bit keeps its old value. The stored word appears on the read ports in the cycle after the write edge.
- R3: If a write requests previous-privilege bits [12:11] = 2'b10, those two bits keep their old value. The other writable fields of the same write still take effect.
- R4: If supervisor mode is absent, a request of bits [12:11] = 2'b01 leaves the field unchanged. If user mode is absent, a request of 2'b00 leaves it unchanged. 2'b11 is always accepted, and so is any encoding whose mode is present.
- R5: Floating-point state bits [14:13] are forced to 2'b11 after the merge when they are nonzero, so they only ever read 2'b00 or 2'b11.
- R6: On every write, bit 31 is set exactly when bits [14:13] are 2'b11 or bits [16:15] are 2'b11.
- R7: The flush output is high for exactly the one cycle after a write edge, and only when the requested value differs from the held value in bit 11, 12, 17, 18 or 19. The requested value is the data merged through the view. This holds even if R3 or R4 then rejects the change. Without a write the flush output is low.
- R8: The supervisor read port equals the full word ANDed with the bit set 0, 1, 4, 5, 8, 13, 14, 15, 16, 18, 19 and 31 (0x800DE133).
- R9: A supervisor-view write (view select = 1) takes only the bits of 0x800DE133 from the data and the rest from the held word. It then applies R2 to R6 to that merged value. The machine-only fields (bits 3, 7, 11, 12, 17) can therefore never change through this view.
- R10: When the write enable is low, the full word is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sview | input | 1 | 1 = write through the supervisor view, 0 = machine view |
| wr_data | input | XLEN | Write data |
| s_mode_present | input | 1 | Supervisor mode is implemented |
| u_mode_present | input | 1 | User mode is implemented |
| m_rdata | output | XLEN | Full status word |
| s_rdata | output | XLEN | Supervisor view of the status word |
| tlb_flush | output | 1 | One-cycle translation flush pulse |

## Verification
Random writes with random view select and random capability inputs run against a bench model of the merge and legalisation rules. Each one is checked on both read ports and on the flush pulse. Directed writes single out each previous-privilege encoding under each capability setting, which separates rejection from acceptance. Other directed writes set the floating-point field to 01 and to 10, which separates the collapse to dirty from plain storage. Writes of all ones through each view show that fields outside each mask stay put. Writes that change only a non-translation bit, and a rejected previous-privilege request, show the difference between the flush rule on the requested value and a flush rule on the stored value.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
   // bit positions of the status word fields
   localparam int unsigned B_UIE  = 0;
   localparam int unsigned B_SIE  = 1;
   localparam int unsigned B_MIE  = 3;
   localparam int unsigned B_UPIE = 4;
   localparam int unsigned B_SPIE = 5;
   localparam int unsigned B_MPIE = 7;
   localparam int unsigned B_SPP  = 8;
   localparam int unsigned B_PPL  = 11;   // previous privilege, 2 bits
   localparam int unsigned B_FPS  = 13;   // floating-point state, 2 bits
   localparam int unsigned B_XST  = 15;   // extension state, 2 bits
   localparam int unsigned B_MPRV = 17;
   localparam int unsigned B_SUM  = 18;
   localparam int unsigned B_MXR  = 19;

   typedef enum logic [1:0] {
      PRIV_USER  = 2'b00,
      PRIV_SUPER = 2'b01,
      PRIV_RSVD  = 2'b10,
      PRIV_MACH  = 2'b11
   } priv_e;

   // bit is writable from the machine view (summary bit excluded)
   function automatic bit is_mwr(input int unsigned idx);
      return idx == B_SIE  || idx == B_MIE  || idx == B_SPIE || idx == B_MPIE ||
             idx == B_SPP  || idx == B_PPL  || idx == B_PPL+1 ||
             idx == B_FPS  || idx == B_FPS+1 || idx == B_MPRV ||
             idx == B_SUM  || idx == B_MXR;
   endfunction

   // bit is visible in the supervisor view; sd_pos is the summary bit
   function automatic bit is_sview(input int unsigned idx, input int unsigned sd_pos);
      return idx == B_UIE  || idx == B_SIE  || idx == B_UPIE || idx == B_SPIE ||
             idx == B_SPP  || idx == B_FPS  || idx == B_FPS+1 ||
             idx == B_XST  || idx == B_XST+1 || idx == B_SUM  ||
             idx == B_MXR  || idx == sd_pos;
   endfunction

   // bit affects address translation
   function automatic bit is_xlat(input int unsigned idx);
      return idx == B_PPL || idx == B_PPL+1 || idx == B_MPRV ||
             idx == B_SUM || idx == B_MXR;
   endfunction
endpackage

// File: rtl/mstat_view_merge.sv
module mstat_view_merge #(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] cur,
   input  logic [XLEN-1:0] wdata,
   input  logic            sview,
   output logic [XLEN-1:0] req
);
   import mstat_pkg::*;
   localparam int unsigned SD_POS = XLEN - 1;

   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (is_sview(i, SD_POS)) begin : g_vis
         assign req[i] = wdata[i];
      end else begin : g_hid
         assign req[i] = sview ? cur[i] : wdata[i];
      end
   end
endmodule

// File: rtl/mstat_field_legal.sv
module mstat_field_legal #(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] cur,
   input  logic [XLEN-1:0] req,
   input  logic            s_ok,
   input  logic            u_ok,
   output logic [XLEN-1:0] nxt
);
   import mstat_pkg::*;
   localparam int unsigned SD_POS = XLEN - 1;

   logic [XLEN-1:0] wmask;
   logic [XLEN-1:0] merged;
   priv_e           ppl_req;
   logic            ppl_bad;

   assign ppl_req = priv_e'(req[B_PPL +: 2]);

   always_comb begin
      unique case (ppl_req)
         PRIV_RSVD:  ppl_bad = 1'b1;
         PRIV_SUPER: ppl_bad = !s_ok;
         PRIV_USER:  ppl_bad = !u_ok;
         default:    ppl_bad = 1'b0;
      endcase
   end

   for (genvar i = 0; i < XLEN; i++) begin : g_mask
      if (i == B_PPL || i == B_PPL + 1) begin : g_ppl
         assign wmask[i] = !ppl_bad;
      end else begin : g_fix
         assign wmask[i] = is_mwr(i);
      end
   end

   assign merged = (cur & ~wmask) | (req & wmask);

   always_comb begin
      nxt = merged;
      if (merged[B_FPS +: 2] != 2'b00) begin
         nxt[B_FPS +: 2] = 2'b11;
      end
      nxt[SD_POS] = (nxt[B_FPS +: 2] == 2'b11) || (nxt[B_XST +: 2] == 2'b11);
   end
endmodule

// File: rtl/mstat_flush_det.sv
module mstat_flush_det #(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] cur,
   input  logic [XLEN-1:0] req,
   input  logic            wr,
   output logic            flush_d
);
   import mstat_pkg::*;

   logic [XLEN-1:0] xmask;

   for (genvar i = 0; i < XLEN; i++) begin : g_xm
      assign xmask[i] = is_xlat(i);
   end

   assign flush_d = wr && (((cur ^ req) & xmask) != '0);
endmodule

// File: rtl/mstat_legalizer.sv
module mstat_legalizer #(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_sview,
   input  logic [XLEN-1:0] wr_data,
   input  logic            s_mode_present,
   input  logic            u_mode_present,
   output logic [XLEN-1:0] m_rdata,
   output logic [XLEN-1:0] s_rdata,
   output logic            tlb_flush
);
   import mstat_pkg::*;
   localparam int unsigned SD_POS = XLEN - 1;

   initial begin
      assert (XLEN == 32 || XLEN == 64)
         else $error("mstat_legalizer: XLEN must be 32 or 64");
   end

   logic [XLEN-1:0] stat_q;
   logic [XLEN-1:0] req;
   logic [XLEN-1:0] nxt;
   logic            flush_d;
   logic            flush_q;

   mstat_view_merge #(.XLEN(XLEN)) u_merge (
      .cur   (stat_q),
      .wdata (wr_data),
      .sview (wr_sview),
      .req   (req)
   );

   mstat_field_legal #(.XLEN(XLEN)) u_legal (
      .cur  (stat_q),
      .req  (req),
      .s_ok (s_mode_present),
      .u_ok (u_mode_present),
      .nxt  (nxt)
   );

   mstat_flush_det #(.XLEN(XLEN)) u_flush (
      .cur     (stat_q),
      .req     (req),
      .wr      (wr_en),
      .flush_d (flush_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q  <= '0;
         flush_q <= 1'b0;
      end else begin
         if (wr_en) begin
            stat_q <= nxt;
         end
         flush_q <= flush_d;
      end
   end

   for (genvar i = 0; i < XLEN; i++) begin : g_sv
      if (is_sview(i, SD_POS)) begin : g_on
         assign s_rdata[i] = stat_q[i];
      end else begin : g_off
         assign s_rdata[i] = 1'b0;
      end
   end

   assign m_rdata   = stat_q;
   assign tlb_flush = flush_q;
endmodule

// File: rtl/mstat_legalizer_chk.sv
module mstat_legalizer_chk #(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic            wr_sview,
   input logic [XLEN-1:0] wr_data,
   input logic            s_mode_present,
   input logic            u_mode_present,
   input logic [XLEN-1:0] m_rdata,
   input logic [XLEN-1:0] s_rdata,
   input logic            tlb_flush
);
   localparam logic [XLEN-1:0] KEEP = ~(XLEN'(32'h000E_79AA) | (XLEN'(1) << (XLEN-1)));
   localparam logic [XLEN-1:0] SVM  = XLEN'(32'h000D_E133) | (XLEN'(1) << (XLEN-1));

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2
   keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((m_rdata & KEEP) == ($past(m_rdata) & KEEP)));

   // R3
   ppl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sview && wr_data[12:11] == 2'b10) |=> $stable(m_rdata[12:11]));

   // R4
   ppl_nos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sview && !s_mode_present && wr_data[12:11] == 2'b01) |=> $stable(m_rdata[12:11]));

   // R4
   ppl_nou_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sview && !u_mode_present && wr_data[12:11] == 2'b00) |=> $stable(m_rdata[12:11]));

   // R5
   fs_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_rdata[14:13] == 2'b00 || m_rdata[14:13] == 2'b11);

   // R6
   sd_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_rdata[XLEN-1] == (m_rdata[14:13] == 2'b11 || m_rdata[16:15] == 2'b11));

   // R7
   flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && tlb_flush |-> $past(wr_en));

   // R8
   sview_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_rdata == (m_rdata & SVM));

   // R9
   sview_mfield_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sview) |=> ($stable(m_rdata[3]) && $stable(m_rdata[7]) &&
                               $stable(m_rdata[12:11]) && $stable(m_rdata[17])));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(wr_en) |-> $stable(m_rdata));
endmodule

bind mstat_legalizer mstat_legalizer_chk #(.XLEN(XLEN)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .wr_sview       (wr_sview),
   .wr_data        (wr_data),
   .s_mode_present (s_mode_present),
   .u_mode_present (u_mode_present),
   .m_rdata        (m_rdata),
   .s_rdata        (s_rdata),
   .tlb_flush      (tlb_flush)
);

// File: tb/mstat_legalizer_tb.sv
module mstat_legalizer_tb;
   localparam logic [31:0] WMASK = 32'h000E_79AA;
   localparam logic [31:0] SMASK = 32'h800D_E133;
   localparam logic [31:0] XMASK = 32'h000E_1800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sview = 1'b0;
   logic [31:0] wr_data = '0;
   logic        s_mode_present = 1'b1;
   logic        u_mode_present = 1'b1;
   logic [31:0] m_rdata;
   logic [31:0] s_rdata;
   logic        tlb_flush;

   int checks = 0;
   int errors = 0;
   logic [31:0] model = '0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mstat_legalizer #(.XLEN(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sview(wr_sview),
      .wr_data(wr_data), .s_mode_present(s_mode_present),
      .u_mode_present(u_mode_present), .m_rdata(m_rdata),
      .s_rdata(s_rdata), .tlb_flush(tlb_flush)
   );

   function automatic logic [31:0] req_of(input logic [31:0] cur, input logic [31:0] d,
                                          input logic sv);
      return sv ? ((cur & ~SMASK) | (d & SMASK)) : d;
   endfunction

   function automatic logic [31:0] next_of(input logic [31:0] cur, input logic [31:0] d,
                                           input logic sv, input logic s, input logic u);
      logic [31:0] r, m, n;
      r = req_of(cur, d, sv);
      m = WMASK;
      if (r[12:11] == 2'b10 || (r[12:11] == 2'b01 && !s) || (r[12:11] == 2'b00 && !u))
         m[12:11] = 2'b00;
      n = (cur & ~m) | (r & m);
      if (n[14:13] != 2'b00) n[14:13] = 2'b11;
      n[31] = (n[14:13] == 2'b11) || (n[16:15] == 2'b11);
      return n;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic do_write(input string tag, input logic [31:0] d, input logic sv,
                           input logic s, input logic u);
      logic fl;
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; wr_sview = sv;
      s_mode_present = s; u_mode_present = u;
      fl = ((req_of(model, d, sv) ^ model) & XMASK) != 0;
      model = next_of(model, d, sv, s, u);
      @(negedge clk);
      wr_en = 1'b0;
      check({tag, " full"}, m_rdata, model);
      check({tag, " R8 sview"}, s_rdata, model & SMASK);
      check({tag, " R7 flush"}, {31'd0, tlb_flush}, {31'd0, fl});
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      check({tag, " R10 hold"}, m_rdata, model);
      check({tag, " R7 no flush"}, {31'd0, tlb_flush}, 32'd0);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset full", m_rdata, 32'h0);
      check("R1 reset flush", {31'd0, tlb_flush}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset full", m_rdata, 32'h0);
      check("R1 after reset sview", s_rdata, 32'h0);

      // R2: all ones through machine view
      do_write("R2 ones", 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1);
      check("R2 exact", m_rdata, 32'h800E_79AA);
      idle_check("R10 a");
      // R3: reserved encoding keeps 11, other fields still cleared
      do_write("R3 rsvd", 32'h0000_1000, 1'b0, 1'b1, 1'b1);
      check("R3 ppl kept", {30'd0, m_rdata[12:11]}, 32'd3);
      // R4
      do_write("R4 to user", 32'h0000_0000, 1'b0, 1'b1, 1'b1);
      do_write("R4 super absent", 32'h0000_0800, 1'b0, 1'b0, 1'b1);
      check("R4 nos kept", {30'd0, m_rdata[12:11]}, 32'd0);
      do_write("R4 super present", 32'h0000_0800, 1'b0, 1'b1, 1'b0);
      do_write("R4 user absent", 32'h0000_0000, 1'b0, 1'b1, 1'b0);
      check("R4 nou kept", {30'd0, m_rdata[12:11]}, 32'd1);
      do_write("R4 mach", 32'h0000_1800, 1'b0, 1'b0, 1'b0);
      // R5 / R6
      do_write("R5 fs01", 32'h0000_3800, 1'b0, 1'b1, 1'b1);
      check("R5 fs01 dirty", m_rdata, 32'h8000_7800);
      do_write("R5 fs10", 32'h0000_5800, 1'b0, 1'b1, 1'b1);
      check("R6 sd set", {31'd0, m_rdata[31]}, 32'd1);
      do_write("R6 fs off", 32'h8000_1800, 1'b0, 1'b1, 1'b1);
      check("R6 sd clear", {31'd0, m_rdata[31]}, 32'd0);
      // R7: non-translation change gives no flush
      do_write("R7 mie only", 32'h0000_1808, 1'b0, 1'b1, 1'b1);
      // R9: supervisor ones leave machine-only fields
      do_write("R9 sv ones", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
      check("R9 mfields", m_rdata & 32'h0002_1888, 32'h0000_1808);
      do_write("R9 sv zero", 32'h0000_0000, 1'b1, 1'b1, 1'b1);
      idle_check("R10 b");

      for (int k = 0; k < 400; k++) begin
         logic [31:0] d;
         d = $urandom();
         do_write("R2 random", d, 1'($urandom()), 1'($urandom()), 1'($urandom()));
         if ($urandom_range(0, 3) == 0) idle_check("R10 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule